// File: doc/BRIEF.md
# Microwire Serial Master

This block drives a Microwire-style serial link as its master. It takes control words from a show-ahead transmit FIFO and shifts each one out as a control frame. After the control frame it runs a data frame. In transmit direction the data frame carries the next FIFO word to the slave. In receive direction the data frame collects a word from the slave and pushes it into a receive FIFO. Three static configuration inputs set how a transfer runs: the data direction, sequential versus nonsequential receive, and an optional slave-ready handshake that holds the link after each control frame.

The serial clock idles low. The master changes `sdo` on falling edges and samples `sdi` on rising edges, most significant bit first. A single active-low select frames each transfer. The data direction and the sequencing mode decide when a transfer ends. The configuration inputs are expected to stay constant while `busy` is high.

Top module: `mw_master`

## Requirements
- R1: While `slave_en` is 0 or `tx_empty` is 1, no transfer starts: `ss_n` stays 1, `busy` stays 0 and `tx_pop` stays 0. After reset `ss_n`=1, `sclk`=0, `busy`=0, `rx_push`=0.
- R2: Every transfer opens with a control frame, whatever the direction. The frame is the low `CTRL_W` bits of a popped FIFO word, sent MSB first. `sdo` changes only on falling `sclk` edges and holds steady at each rising edge.
- R3: With `dir_tx`=1, the FIFO word that follows a control word is sent as a `DATA_W`-bit data frame, MSB first, right after its control frame.
- R4: With `dir_tx`=1, if the FIFO is non-empty at the end of a data frame, the next control frame follows with `ss_n` held low. If the FIFO is empty, `ss_n` is released.
- R5: With `dir_tx`=0, `sdo` is 0 throughout every data frame. `sdi` is sampled MSB first on rising edges. `rx_push` pulses high for one cycle, carrying the word on `rx_data`, at the clock edge where the last falling `sclk` edge of that frame occurs. `rx_push` never fires with `dir_tx`=1.
- R6: With `dir_tx`=0 and `seq_mode`=0, each control frame is followed by exactly one data frame. `ss_n` is released in the same cycle that `rx_push` fires, so each further control word opens a new selection.
- R7: With `dir_tx`=0 and `seq_mode`=1, one control frame is followed by `rx_len_m1`+1 back-to-back data frames inside one selection, and then `ss_n` is released.
- R8: With `hs_en`=1, `sclk` stays low after a control frame until `slave_rdy` is 1, and only then does the data frame start. With `hs_en`=0, `slave_rdy` has no effect.
- R9: `busy` is 1 whenever `ss_n` is 0. Between two selections `ss_n` stays high for at least two clock cycles.
- R10: `sclk` toggles only while `ss_n` is 0. Each high phase of `sclk` lasts exactly `HALF_DIV` clock cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| slave_en | input | 1 | Slave enabled; allows transfers to start |
| hs_en | input | 1 | Enable the slave-ready wait after control frames |
| dir_tx | input | 1 | 1: master sends data frames; 0: master receives them |
| seq_mode | input | 1 | 1: sequential receive; 0: nonsequential |
| rx_len_m1 | input | LEN_W | Sequential receive frame count minus one |
| tx_data | input | WORD_W | Head word of the transmit FIFO (show-ahead) |
| tx_empty | input | 1 | Transmit FIFO empty |
| tx_pop | output | 1 | Pop the transmit FIFO head this cycle |
| rx_data | output | DATA_W | Received data word |
| rx_push | output | 1 | Push `rx_data` into the receive FIFO |
| ss_n | output | 1 | Active-low slave select |
| sclk | output | 1 | Serial clock |
| sdo | output | 1 | Serial data to the slave |
| sdi | input | 1 | Serial data from the slave |
| slave_rdy | input | 1 | Slave-ready handshake input |
| busy | output | 1 | Transfer in progress |

## Verification
A new selection drops `ss_n` one clock edge after `slave_en` and a non-empty FIFO are seen together. The first rising `sclk` edge comes `HALF_DIV` cycles later, and each bit lasts `2*HALF_DIV` cycles. A received word appears on `rx_push` at the same edge as the last falling `sclk` edge of its frame, and `ss_n` rises at that edge in nonsequential mode. Rather than counting fixed cycles, the bench follows the link as a slave would, aligning each check to the edges that define it: it samples `sdo` on each rising `sclk` edge, changes `sdi` on each falling edge, and reads `rx_push` and the select at clock falling edges. The handshake stall is checked by holding `slave_rdy` low for 40 cycles and requiring that no rising `sclk` edge occurs in that window.

// File: rtl/mw_pkg.sv
// Shared types for the Microwire master: the transfer sequencer state.
package mw_pkg;
    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_CTRL   = 3'd1,
        ST_HSWAIT = 3'd2,
        ST_LOADD  = 3'd3,
        ST_DATA   = 3'd4,
        ST_GAP    = 3'd5
    } mw_state_t;
endpackage

// File: rtl/mw_sclk_gen.sv
// Serial clock generator. While run is high, sclk toggles every HALF_DIV
// clock cycles, starting low. rise_evt and fall_evt flag the cycle whose
// closing edge makes sclk rise or fall. Assumes run drops only while sclk is low.
module mw_sclk_gen #(
    parameter int HALF_DIV = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic sclk,
    output logic rise_evt,
    output logic fall_evt
);
    localparam int CNT_W = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(HALF_DIV - 1);

    logic [CNT_W-1:0] cnt_q;
    logic             wrap;

    assign wrap     = run && (cnt_q == LAST);
    assign rise_evt = wrap && !sclk;
    assign fall_evt = wrap && sclk;

    // Divide the system clock and toggle sclk at each phase end.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            cnt_q <= '0;
            sclk  <= 1'b0;
        end else if (wrap) begin
            cnt_q <= '0;
            sclk  <= ~sclk;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/mw_shifter.sv
// Frame shifter. Loads a control word (CTRL_W bits) or a data word (DATA_W
// bits) left-aligned, presents the MSB on msb, shifts on falling events and
// samples sdi into a receive register on rising events. frame_done flags
// the falling event that ends the last bit of the frame.
module mw_shifter #(
    parameter int CTRL_W = 8,
    parameter int DATA_W = 16,
    parameter int WORD_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              load_ctrl,
    input  logic [WORD_W-1:0] load_word,
    input  logic              rise_evt,
    input  logic              fall_evt,
    input  logic              sdi,
    output logic              msb,
    output logic              frame_done,
    output logic [DATA_W-1:0] rx_word
);
    localparam int BC_W = (WORD_W > 1) ? $clog2(WORD_W) : 1;

    logic [WORD_W-1:0] sreg_q;
    logic [BC_W-1:0]   bcnt_q;
    logic [DATA_W-1:0] rreg_q;

    assign msb        = sreg_q[WORD_W-1];
    assign frame_done = fall_evt && (bcnt_q == '0);
    assign rx_word    = rreg_q;

    // Load a new frame, or shift out one bit per falling event.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sreg_q <= '0;
            bcnt_q <= '0;
        end else if (load) begin
            if (load_ctrl) begin
                sreg_q <= WORD_W'(load_word[CTRL_W-1:0]) << (WORD_W - CTRL_W);
                bcnt_q <= BC_W'(CTRL_W - 1);
            end else begin
                sreg_q <= WORD_W'(load_word[DATA_W-1:0]) << (WORD_W - DATA_W);
                bcnt_q <= BC_W'(DATA_W - 1);
            end
        end else if (fall_evt && (bcnt_q != '0)) begin
            sreg_q <= sreg_q << 1;
            bcnt_q <= bcnt_q - 1'b1;
        end
    end

    // Capture sdi on each rising event, MSB first.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rreg_q <= '0;
        end else if (rise_evt) begin
            rreg_q <= {rreg_q[DATA_W-2:0], sdi};
        end
    end
endmodule

// File: rtl/mw_seq_ctrl.sv
// Transfer sequencer. Starts a selection when the slave is enabled and the
// FIFO holds a word, runs a control frame, optionally waits for slave_rdy,
// then runs data frames. Direction and mode decide whether to chain, repeat
// or end. Assumes configuration inputs are static while a transfer runs.
module mw_seq_ctrl
    import mw_pkg::*;
#(
    parameter int LEN_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             slave_en,
    input  logic             tx_empty,
    input  logic             dir_tx,
    input  logic             seq_mode,
    input  logic             hs_en,
    input  logic             slave_rdy,
    input  logic [LEN_W-1:0] rx_len_m1,
    input  logic             frame_done,
    output mw_state_t        st,
    output logic             tx_pop,
    output logic             load,
    output logic             load_ctrl,
    output logic             run,
    output logic             take
);
    mw_state_t        st_q, st_d;
    logic [LEN_W-1:0] fcnt_q;
    logic             cnt_clr, cnt_inc;

    assign st  = st_q;
    assign run = (st_q == ST_CTRL) || (st_q == ST_DATA);

    // Next-state and strobe decode.
    always_comb begin
        st_d      = st_q;
        tx_pop    = 1'b0;
        load      = 1'b0;
        load_ctrl = 1'b0;
        take      = 1'b0;
        cnt_clr   = 1'b0;
        cnt_inc   = 1'b0;
        case (st_q)
            ST_IDLE: begin
                if (slave_en && !tx_empty) begin
                    tx_pop    = 1'b1;
                    load      = 1'b1;
                    load_ctrl = 1'b1;
                    st_d      = ST_CTRL;
                end
            end
            ST_CTRL: begin
                if (frame_done) st_d = hs_en ? ST_HSWAIT : ST_LOADD;
            end
            ST_HSWAIT: begin
                if (slave_rdy) st_d = ST_LOADD;
            end
            ST_LOADD: begin
                if (!dir_tx) begin
                    load    = 1'b1;
                    cnt_clr = 1'b1;
                    st_d    = ST_DATA;
                end else if (!tx_empty) begin
                    tx_pop = 1'b1;
                    load   = 1'b1;
                    st_d   = ST_DATA;
                end
            end
            ST_DATA: begin
                if (frame_done) begin
                    if (dir_tx) begin
                        if (!tx_empty) begin
                            tx_pop    = 1'b1;
                            load      = 1'b1;
                            load_ctrl = 1'b1;
                            st_d      = ST_CTRL;
                        end else begin
                            st_d = ST_GAP;
                        end
                    end else begin
                        take = 1'b1;
                        if (seq_mode && (fcnt_q != rx_len_m1)) begin
                            load    = 1'b1;
                            cnt_inc = 1'b1;
                        end else begin
                            st_d = ST_GAP;
                        end
                    end
                end
            end
            ST_GAP:  st_d = ST_IDLE;
            default: st_d = ST_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= ST_IDLE;
        else        st_q <= st_d;
    end

    // Count received frames within a sequential selection.
    always_ff @(posedge clk) begin
        if (!rst_n || cnt_clr) fcnt_q <= '0;
        else if (cnt_inc)      fcnt_q <= fcnt_q + 1'b1;
    end
endmodule

// File: rtl/mw_master.sv
// Microwire master top. Ties the sequencer, clock generator and shifter
// together, forms select, busy and sdo from the sequencer state, and
// registers received words toward the receive FIFO. Assumes tx_data is the
// show-ahead head of the transmit FIFO and sdi/slave_rdy are synchronous.
module mw_master
    import mw_pkg::*;
#(
    parameter  int CTRL_W   = 8,
    parameter  int DATA_W   = 16,
    parameter  int HALF_DIV = 2,
    parameter  int LEN_W    = 4,
    localparam int WORD_W   = (CTRL_W > DATA_W) ? CTRL_W : DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              slave_en,
    input  logic              hs_en,
    input  logic              dir_tx,
    input  logic              seq_mode,
    input  logic [LEN_W-1:0]  rx_len_m1,
    input  logic [WORD_W-1:0] tx_data,
    input  logic              tx_empty,
    output logic              tx_pop,
    output logic [DATA_W-1:0] rx_data,
    output logic              rx_push,
    output logic              ss_n,
    output logic              sclk,
    output logic              sdo,
    input  logic              sdi,
    input  logic              slave_rdy,
    output logic              busy
);
    mw_state_t         st;
    logic              load, load_ctrl, run, take;
    logic              rise_evt, fall_evt, frame_done, msb;
    logic [WORD_W-1:0] ld_word;
    logic [DATA_W-1:0] rx_word;

    mw_seq_ctrl #(.LEN_W(LEN_W)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .slave_en(slave_en), .tx_empty(tx_empty),
        .dir_tx(dir_tx), .seq_mode(seq_mode), .hs_en(hs_en),
        .slave_rdy(slave_rdy), .rx_len_m1(rx_len_m1),
        .frame_done(frame_done), .st(st), .tx_pop(tx_pop), .load(load),
        .load_ctrl(load_ctrl), .run(run), .take(take)
    );

    mw_sclk_gen #(.HALF_DIV(HALF_DIV)) u_clk (
        .clk(clk), .rst_n(rst_n), .run(run), .sclk(sclk),
        .rise_evt(rise_evt), .fall_evt(fall_evt)
    );

    mw_shifter #(.CTRL_W(CTRL_W), .DATA_W(DATA_W), .WORD_W(WORD_W)) u_shift (
        .clk(clk), .rst_n(rst_n), .load(load), .load_ctrl(load_ctrl),
        .load_word(ld_word), .rise_evt(rise_evt), .fall_evt(fall_evt),
        .sdi(sdi), .msb(msb), .frame_done(frame_done), .rx_word(rx_word)
    );

    // Receive data frames shift out zeros; others take the FIFO head.
    assign ld_word = (load_ctrl || dir_tx) ? tx_data : '0;

    assign ss_n = !((st == ST_CTRL) || (st == ST_HSWAIT) ||
                    (st == ST_LOADD) || (st == ST_DATA));
    assign busy = (st != ST_IDLE);
    assign sdo  = msb && ((st == ST_CTRL) || ((st == ST_DATA) && dir_tx));

    // Register each completed receive word toward the receive FIFO.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_push <= 1'b0;
            rx_data <= '0;
        end else begin
            rx_push <= take;
            if (take) rx_data <= rx_word;
        end
    end
endmodule

// File: rtl/mw_master_chk.sv
// Protocol checker for mw_master, bound to every instance of the top.
module mw_master_chk
    import mw_pkg::*;
(
    input logic      clk,
    input logic      rst_n,
    input logic      slave_en,
    input logic      tx_empty,
    input logic      tx_pop,
    input logic      dir_tx,
    input logic      seq_mode,
    input logic      slave_rdy,
    input logic      rx_push,
    input logic      ss_n,
    input logic      sclk,
    input logic      sdo,
    input logic      busy,
    input mw_state_t st
);
    p_pop_guard_r1: assert property (@(posedge clk) disable iff (!rst_n)
        tx_pop |-> !tx_empty);

    p_hold_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !slave_en) |=> !busy);

    p_sdo_steady_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!ss_n && $rose(sclk)) |-> $stable(sdo));

    p_push_dir_r5: assert property (@(posedge clk) disable iff (!rst_n)
        rx_push |-> !dir_tx);

    p_push_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
        rx_push |=> !rx_push);

    p_nonseq_release_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_push && !seq_mode) |-> ss_n);

    p_hs_stall_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ((st == ST_HSWAIT) && !slave_rdy) |=> ((st == ST_HSWAIT) && !sclk));

    p_busy_sel_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !ss_n |-> busy);

    p_gap_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ss_n) |=> ss_n);

    p_sclk_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        ss_n |-> !sclk);
endmodule

bind mw_master mw_master_chk u_chk (
    .clk(clk), .rst_n(rst_n), .slave_en(slave_en), .tx_empty(tx_empty),
    .tx_pop(tx_pop), .dir_tx(dir_tx), .seq_mode(seq_mode),
    .slave_rdy(slave_rdy), .rx_push(rx_push), .ss_n(ss_n), .sclk(sclk),
    .sdo(sdo), .busy(busy), .st(st)
);

// File: tb/mw_master_test.sv
// Scoreboard bench: driver tasks queue expected frames and words, a slave
// model and a receive monitor pop and compare them as the link runs.
module mw_master_test;
    localparam int CW = 6;
    localparam int DW = 8;
    localparam int HD = 2;
    localparam int LW = 4;
    localparam int WW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          slave_en = 1'b0, hs_en = 1'b0, dir_tx = 1'b0, seq_mode = 1'b0;
    logic [LW-1:0] rx_len_m1 = '0;
    logic [WW-1:0] tx_data = '0;
    logic          tx_empty = 1'b1;
    logic          tx_pop;
    logic [DW-1:0] rx_data;
    logic          rx_push, ss_n, sclk, sdo, busy;
    logic          sdi = 1'b0, slave_rdy = 1'b0;

    always #10 clk = ~clk;

    mw_master #(.CTRL_W(CW), .DATA_W(DW), .HALF_DIV(HD), .LEN_W(LW)) uut (
        .clk(clk), .rst_n(rst_n), .slave_en(slave_en), .hs_en(hs_en),
        .dir_tx(dir_tx), .seq_mode(seq_mode), .rx_len_m1(rx_len_m1),
        .tx_data(tx_data), .tx_empty(tx_empty), .tx_pop(tx_pop),
        .rx_data(rx_data), .rx_push(rx_push), .ss_n(ss_n), .sclk(sclk),
        .sdo(sdo), .sdi(sdi), .slave_rdy(slave_rdy), .busy(busy)
    );

    int n_chk = 0, n_fail = 0;
    logic [WW-1:0] fifo_q[$];
    logic [WW-1:0] exp_ctrl[$], exp_txd[$], slv_q[$], exp_rx[$];
    int kind = 0, idx = 0, win_ctrl = 0, win_data = 0;
    int win_count = 0, last_ctrl = 0, last_data = 0, ctrl_seen = 0, rises = 0;
    int push_cnt = 0, rx_sdo_bad = 0, hi_run = 0, hi_runs = 0, hi_bad = 0;
    int ss_hi = 100, gap_bad = 0, busy_bad = 0;
    logic [WW-1:0] cap = '0, rxw = '0;

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Transmit FIFO model: pops at the edge, head refreshed at falling edges.
    always @(posedge clk) if (tx_pop && fifo_q.size() > 0) void'(fifo_q.pop_front());
    always @(negedge clk) begin
        tx_empty = (fifo_q.size() == 0);
        tx_data  = (fifo_q.size() > 0) ? fifo_q[0] : '0;
    end

    // Slave model: sample sdo on rising sclk, score complete frames.
    always @(posedge sclk) if (rst_n && !ss_n) begin
        rises++;
        cap = {cap[WW-2:0], sdo};
        if (kind == 1 && !dir_tx && sdo) rx_sdo_bad++;
        idx++;
        if (kind == 0 && idx == CW) begin
            chk(exp_ctrl.size() > 0 && cap[CW-1:0] == exp_ctrl[0][CW-1:0], "R2",
                "control frame", int'(cap[CW-1:0]),
                exp_ctrl.size() > 0 ? int'(exp_ctrl[0][CW-1:0]) : -1);
            if (exp_ctrl.size() > 0) void'(exp_ctrl.pop_front());
            win_ctrl++; ctrl_seen++; kind = 1; idx = 0;
            if (!dir_tx) rxw = (slv_q.size() > 0) ? slv_q.pop_front() : '0;
        end else if (kind == 1 && idx == DW) begin
            win_data++;
            if (dir_tx) begin
                chk(exp_txd.size() > 0 && cap == exp_txd[0], "R3", "tx data frame",
                    int'(cap), exp_txd.size() > 0 ? int'(exp_txd[0]) : -1);
                if (exp_txd.size() > 0) void'(exp_txd.pop_front());
            end
            kind = (dir_tx || !seq_mode) ? 0 : 1;
            idx = 0;
            if (kind == 1) rxw = (slv_q.size() > 0) ? slv_q.pop_front() : '0;
        end
    end

    // Slave model: drive sdi after each falling sclk during receive data.
    always @(negedge sclk) if (rst_n && !ss_n) begin
        sdi = (kind == 1 && !dir_tx && idx < DW) ? rxw[DW-1-idx] : 1'b0;
    end

    // Close a selection window and record its frame counts.
    always @(posedge ss_n) if (rst_n) begin
        win_count++; last_ctrl = win_ctrl; last_data = win_data;
        win_ctrl = 0; win_data = 0; kind = 0; idx = 0; sdi = 1'b0;
    end

    // Receive monitor (R5): compare each pushed word in order.
    always @(negedge clk) if (rst_n && rx_push) begin
        push_cnt++;
        chk(exp_rx.size() > 0 && rx_data == exp_rx[0], "R5", "received word",
            int'(rx_data), exp_rx.size() > 0 ? int'(exp_rx[0]) : -1);
        if (exp_rx.size() > 0) void'(exp_rx.pop_front());
    end

    // Level monitors for R9 and R10.
    always @(negedge clk) if (rst_n) begin
        if (sclk) hi_run++;
        else begin
            if (hi_run != 0) begin hi_runs++; if (hi_run != HD) hi_bad++; end
            hi_run = 0;
        end
        if (!ss_n && !busy) busy_bad++;
        if (ss_n) ss_hi++;
        else begin
            if (ss_hi > 0 && ss_hi < 2) gap_bad++;
            ss_hi = 0;
        end
    end

    task automatic push_tx_pair(input logic [WW-1:0] c, input logic [WW-1:0] d);
        fifo_q.push_back(c); fifo_q.push_back(d);
        exp_ctrl.push_back(c); exp_txd.push_back(d);
    endtask

    task automatic push_rx_ctrl(input logic [WW-1:0] c);
        fifo_q.push_back(c); exp_ctrl.push_back(c);
    endtask

    task automatic push_slave(input logic [WW-1:0] w);
        slv_q.push_back(w); exp_rx.push_back(w);
    endtask

    task automatic wait_windows(input int target);
        int t = 0;
        while (win_count < target && t < 20000) begin @(negedge clk); t++; end
        repeat (6) @(negedge clk);
        chk(win_count >= target, "R4", "selection completed", win_count, target);
    endtask

    task automatic finish_up;
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL R1 watchdog expired: got %0d expected %0d", 1, 0);
        finish_up();
    end

    initial begin
        int w0, p0, r0;
        repeat (4) @(negedge clk);
        chk(ss_n == 1'b1, "R1", "reset ss_n", int'(ss_n), 1);
        chk(sclk == 1'b0, "R1", "reset sclk", int'(sclk), 0);
        chk(busy == 1'b0, "R1", "reset busy", int'(busy), 0);
        chk(rx_push == 1'b0, "R1", "reset rx_push", int'(rx_push), 0);
        rst_n = 1'b1;

        // R1: words queued but slave disabled, then enabled with empty FIFO.
        fifo_q.push_back(8'h11); fifo_q.push_back(8'h22);
        w0 = 0;
        for (int i = 0; i < 30; i++) begin @(negedge clk); if (busy || !ss_n || tx_pop) w0++; end
        chk(w0 == 0, "R1", "no start while disabled", w0, 0);
        fifo_q.delete();
        repeat (2) @(negedge clk);
        slave_en = 1'b1;
        w0 = 0;
        for (int i = 0; i < 30; i++) begin @(negedge clk); if (busy || !ss_n || tx_pop) w0++; end
        chk(w0 == 0, "R1", "no start on empty FIFO", w0, 0);
        slave_en = 1'b0;

        // R3/R4: three transmit pairs form one selection.
        dir_tx = 1'b1;
        push_tx_pair(8'h2D, 8'hA5); push_tx_pair(8'h13, 8'h3C); push_tx_pair(8'h3F, 8'h81);
        repeat (2) @(negedge clk);
        w0 = win_count; slave_en = 1'b1;
        wait_windows(w0 + 1);
        chk(win_count == w0 + 1, "R4", "tx chained selections", win_count - w0, 1);
        chk(last_ctrl == 3 && last_data == 3, "R4", "tx pairs in window",
            last_ctrl * 10 + last_data, 33);
        slave_en = 1'b0;

        // R6: nonsequential receive, one data frame per selection.
        dir_tx = 1'b0; seq_mode = 1'b0; rx_len_m1 = 4'd3;
        push_rx_ctrl(8'h25); push_rx_ctrl(8'h0A);
        push_slave(8'hC3); push_slave(8'h5E);
        repeat (2) @(negedge clk);
        w0 = win_count; p0 = push_cnt; slave_en = 1'b1;
        wait_windows(w0 + 2);
        chk(win_count == w0 + 2, "R6", "one selection per control", win_count - w0, 2);
        chk(last_ctrl == 1 && last_data == 1, "R6", "frames in window",
            last_ctrl * 10 + last_data, 11);
        chk(push_cnt == p0 + 2, "R5", "receive pushes", push_cnt - p0, 2);
        slave_en = 1'b0;

        // R7: sequential receive of rx_len_m1+1 frames.
        seq_mode = 1'b1; rx_len_m1 = 4'd4;
        push_rx_ctrl(8'h31);
        push_slave(8'h01); push_slave(8'hFE); push_slave(8'h80);
        push_slave(8'h7F); push_slave(8'h96);
        repeat (2) @(negedge clk);
        w0 = win_count; p0 = push_cnt; slave_en = 1'b1;
        wait_windows(w0 + 1);
        chk(last_ctrl == 1 && last_data == 5, "R7", "sequential frames in window",
            last_ctrl * 10 + last_data, 15);
        chk(push_cnt == p0 + 5, "R7", "sequential pushes", push_cnt - p0, 5);
        slave_en = 1'b0; seq_mode = 1'b0;

        // R8: handshake stall until slave_rdy.
        dir_tx = 1'b1; hs_en = 1'b1; slave_rdy = 1'b0;
        push_tx_pair(8'h1B, 8'h6D);
        repeat (2) @(negedge clk);
        w0 = win_count; p0 = ctrl_seen; slave_en = 1'b1;
        for (int t = 0; t < 2000 && ctrl_seen == p0; t++) @(negedge clk);
        repeat (2 * HD + 2) @(negedge clk);
        r0 = rises;
        repeat (40) @(negedge clk);
        chk(rises == r0 && !ss_n && !sclk, "R8", "stall while slave not ready",
            rises - r0, 0);
        slave_rdy = 1'b1;
        wait_windows(w0 + 1);
        chk(last_data == 1, "R8", "data after ready", last_data, 1);
        slave_en = 1'b0;

        // R8: handshake disabled, slave_rdy low is ignored.
        hs_en = 1'b0; slave_rdy = 1'b0;
        push_tx_pair(8'h07, 8'hE4);
        repeat (2) @(negedge clk);
        w0 = win_count; slave_en = 1'b1;
        wait_windows(w0 + 1);
        chk(last_ctrl == 1 && last_data == 1, "R8", "no wait with handshake off",
            last_ctrl * 10 + last_data, 11);
        slave_en = 1'b0;

        repeat (10) @(negedge clk);
        chk(rx_sdo_bad == 0, "R5", "sdo low in receive data", rx_sdo_bad, 0);
        chk(busy_bad == 0, "R9", "busy during select", busy_bad, 0);
        chk(gap_bad == 0, "R9", "select gap length", gap_bad, 0);
        chk(hi_runs > 0 && hi_bad == 0, "R10", "sclk high phase length", hi_bad, 0);
        chk(exp_ctrl.size() == 0 && exp_txd.size() == 0 && exp_rx.size() == 0, "R2",
            "all expected frames seen", exp_ctrl.size() + exp_txd.size() + exp_rx.size(), 0);
        finish_up();
    end
endmodule